// File: doc/BRIEF.md
# Timed-Unlock Nonvolatile Write Controller

This block is the control register and sequencer in front of an on-chip nonvolatile byte memory. Software writes an 8-bit control word over a simple register bus. A write to the memory needs two steps. First software sets an arm bit, which opens a window that closes by itself a few clocks later. Then software sets a strobe bit while that window is open. Only then does the block start a write of the byte on `data_in` to the location on `addr_in`.

The strobe bit stays high while the write is in flight, so software can poll it. A parameterized cycle counter stands in for the memory's write time and raises a one-cycle completion pulse, which clears the strobe. A level-type ready interrupt is raised whenever no write is in flight, the interrupt enable is set and the global interrupt flag is high. Each accepted write also asks the CPU to stall for two cycles. No write can start while the flash self-programming busy input is high.

Top module: `nvm_write_guard`

## Requirements
- R1: Bits 7..4 of the control word always read as zero, and the values written to them have no effect on any output.
- R2: After reset the control word reads 0x00, and `ready_irq`, `cpu_halt`, `mem_start` and `mem_done` are low.
- R3: The arm bit (bit 2) reads one for exactly ARM_CYCLES cycles after the bus write that set it, and then returns to zero without any further bus write.
- R4: A bus write with bit 1 set, made while the arm bit already reads one, starts a write. `mem_start` pulses for one cycle in the next cycle, and `mem_addr`/`mem_data` carry the `addr_in`/`data_in` values present at the strobe.
- R5: A strobe made while the arm bit reads zero is ignored. This includes a single bus write that sets bit 2 and bit 1 together.
- R6: Bit 1 (busy/strobe) reads one for exactly WRITE_CYCLES cycles after an accepted strobe. `mem_done` pulses in the last of these cycles, and bit 1 reads zero after it.
- R7: `ready_irq` is high exactly when bit 3 (interrupt enable) is one, bit 1 is zero and `gie` is high.
- R8: `cpu_halt` is high for exactly two cycles, starting in the cycle after an accepted strobe.
- R9: A strobe made while `flash_busy` is high is ignored.
- R10: A strobe made while a write is in flight is ignored. The latched address and data stay unchanged until the write completes, whatever happens on `addr_in`/`data_in`.
- R11: Bit 0 is a plain read/write bit with no other effect, and bit 3 is written directly from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global interrupt flag |
| flash_busy | input | 1 | Flash self-programming in progress |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 8 | Control word write data |
| addr_in | input | ADDR_W | Current memory address |
| data_in | input | DATA_W | Current data byte |
| ctrl_rdata | output | 8 | Control word read value |
| ready_irq | output | 1 | Level ready interrupt request |
| cpu_halt | output | 1 | CPU stall request |
| mem_start | output | 1 | One-cycle write start to the array |
| mem_done | output | 1 | One-cycle write completion |
| mem_addr | output | ADDR_W | Address latched at write start |
| mem_data | output | DATA_W | Data latched at write start |

## Verification
The hardest situation to reach is a strobe landing on the very last cycle of the arm window, along with its twin one cycle later. An off-by-one in the timeout decides between these two cases. The stimulus arms the window, waits a counted number of cycles at negative edges, and then issues the strobe at exactly the fourth and the fifth rising edge after arming. A second hard case is a fully armed strobe during a write in flight. To reach it, the bench re-arms and strobes again mid-write while it changes the address and data inputs. The scoreboard then shows that no second start appears and that the latched values survive.

// File: rtl/nvm_write_guard.sv
module nvm_write_guard #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 32,
  parameter int ARM_CYCLES   = 4,
  parameter int HALT_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic              flash_busy,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [7:0]        ctrl_rdata,
  output logic              ready_irq,
  output logic              cpu_halt,
  output logic              mem_start,
  output logic              mem_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);

  localparam int WCNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam int ACNT_W = (ARM_CYCLES > 1) ? $clog2(ARM_CYCLES) : 1;
  localparam int HCNT_W = $clog2(HALT_CYCLES + 1);

  logic              irq_en, arm, busy, rd_bit;
  logic [ACNT_W-1:0] arm_cnt;
  logic [WCNT_W-1:0] wr_cnt;
  logic [HCNT_W-1:0] halt_cnt;

  wire unused_hi = ^bus_wdata[7:4];
  wire strobe    = bus_wr & bus_wdata[1];
  wire accept    = strobe & arm & ~busy & ~flash_busy;

  assign ctrl_rdata = {4'b0000, irq_en, arm, busy, rd_bit};
  assign ready_irq  = irq_en & ~busy & gie;
  assign cpu_halt   = (halt_cnt != '0);
  assign mem_done   = busy & (wr_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      rd_bit   <= 1'b0;
      arm      <= 1'b0;
      arm_cnt  <= '0;
      busy     <= 1'b0;
      wr_cnt   <= '0;
      halt_cnt <= '0;
      mem_start <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_start <= accept;

      if (bus_wr) begin
        irq_en <= bus_wdata[3];
        rd_bit <= bus_wdata[0];
      end

      if (bus_wr) begin
        arm     <= bus_wdata[2];
        arm_cnt <= ACNT_W'(ARM_CYCLES - 1);
      end else if (arm) begin
        if (arm_cnt == '0) arm <= 1'b0;
        else               arm_cnt <= arm_cnt - 1'b1;
      end

      if (accept) begin
        busy     <= 1'b1;
        wr_cnt   <= WCNT_W'(WRITE_CYCLES - 1);
        mem_addr <= addr_in;
        mem_data <= data_in;
      end else if (busy) begin
        if (wr_cnt == '0) busy <= 1'b0;
        else              wr_cnt <= wr_cnt - 1'b1;
      end

      if (accept)               halt_cnt <= HCNT_W'(HALT_CYCLES);
      else if (halt_cnt != '0)  halt_cnt <= halt_cnt - 1'b1;
    end
  end

  assert_arm_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm && arm_cnt == '0 && !bus_wr |=> !arm);

  assert_start_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(arm) && mem_start);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done |=> !busy);

  assert_irq_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && irq_en && gie |-> ready_irq);

  assert_halt_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |=> cpu_halt);

  assert_halt_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt && $past(cpu_halt) |=> !cpu_halt);

  assert_no_flash_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(flash_busy));

  assert_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_addr) && $stable(mem_data) && !mem_start);

endmodule

// File: tb/tb_nvm_write_guard.sv
module tb_nvm_write_guard;
  localparam int AW = 9;
  localparam int DW = 8;
  localparam int WC = 20;

  logic clk = 1'b0, rst_n = 1'b0, gie = 1'b0, flash_busy = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [7:0]    ctrl_rdata;
  logic ready_irq, cpu_halt, mem_start, mem_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int checks = 0, errors = 0;
  logic [AW+DW-1:0] expq[$];

  always #2 clk = ~clk;

  nvm_write_guard #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .flash_busy(flash_busy),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .addr_in(addr_in), .data_in(data_in),
    .ctrl_rdata(ctrl_rdata), .ready_irq(ready_irq), .cpu_halt(cpu_halt),
    .mem_start(mem_start), .mem_done(mem_done), .mem_addr(mem_addr), .mem_data(mem_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_start(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_in = a; data_in = d;
    expq.push_back({a, d});
  endtask

  // monitor: every start must match the next expected item (R4, R5, R9, R10)
  always @(negedge clk) begin
    if (rst_n && mem_start) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R5/R9/R10 unexpected start: actual %0h expected none", {mem_addr, mem_data});
      end else begin
        logic [AW+DW-1:0] e;
        e = expq.pop_front();
        if ({mem_addr, mem_data} !== e) begin
          errors++;
          $display("FAIL R4 start contents: actual %0h expected %0h", {mem_addr, mem_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    tick(3);
    chk("R2 rdata", ctrl_rdata, 8'h00);
    chk("R2 outs", {ready_irq, cpu_halt, mem_start, mem_done}, 4'b0000);
    rst_n = 1'b1;
    tick(1);

    wr(8'hF1);
    chk("R1 R11 reserved/read bit", ctrl_rdata, 8'h01);
    chk("R1 no start or halt", {cpu_halt, mem_start}, 2'b00);
    wr(8'hF8);
    chk("R11 ie bit", ctrl_rdata, 8'h08);
    chk("R7 irq low without gie", ready_irq, 1'b0);
    gie = 1'b1; tick(1);
    chk("R7 irq high", ready_irq, 1'b1);
    gie = 1'b0; tick(1);
    chk("R7 irq drops with gie", ready_irq, 1'b0);

    // R3 window length
    wr(8'h04);
    chk("R3 armed", ctrl_rdata[2], 1'b1);
    tick(3);
    chk("R3 still armed at 4th cycle", ctrl_rdata[2], 1'b1);
    tick(1);
    chk("R3 timed out", ctrl_rdata[2], 1'b0);

    // R4 R6 R8 basic write
    expect_start(9'h1A5, 8'h3C);
    wr(8'h04); wr(8'h02);
    addr_in = 9'h011; data_in = 8'hEE;
    chk("R4 busy set", ctrl_rdata[1], 1'b1);
    chk("R8 halt cycle 1", cpu_halt, 1'b1);
    tick(1);
    chk("R8 halt cycle 2", cpu_halt, 1'b1);
    tick(1);
    chk("R8 halt released", cpu_halt, 1'b0);
    n = 3;
    while (1) begin
      if (mem_done) begin
        chk("R6 done on last busy cycle", n, WC);
        chk("R10 latched addr at done", mem_addr, 9'h1A5);
      end
      tick(1);
      if (!ctrl_rdata[1]) break;
      n++;
    end
    chk("R6 busy length", n, WC);

    // R3/R4 boundary: strobe on last armed cycle accepted
    expect_start(9'h0F0, 8'h5A);
    wr(8'h04); tick(3); wr(8'h02);
    chk("R4 strobe on last window cycle", ctrl_rdata[1], 1'b1);
    tick(WC + 2);
    chk("R6 idle again", ctrl_rdata[1], 1'b0);

    // one cycle late: ignored
    wr(8'h04); tick(4); wr(8'h02);
    chk("R5 late strobe ignored", ctrl_rdata[1], 1'b0);
    chk("R5 late strobe no halt", cpu_halt, 1'b0);

    // same-write arm and strobe
    wr(8'h06);
    chk("R5 same-write strobe ignored", ctrl_rdata[1], 1'b0);
    tick(6);

    // flash busy
    flash_busy = 1'b1;
    wr(8'h04); wr(8'h02);
    chk("R9 blocked by flash", ctrl_rdata[1], 1'b0);
    chk("R9 no halt", cpu_halt, 1'b0);
    flash_busy = 1'b0;
    tick(6);

    // R10 and R7 across a write in flight
    gie = 1'b1;
    expect_start(9'h133, 8'hC7);
    wr(8'h0C); wr(8'h0A);
    chk("R7 irq low while busy", ready_irq, 1'b0);
    addr_in = 9'h000; data_in = 8'h00;
    wr(8'h0C); wr(8'h0A);
    chk("R10 still busy", ctrl_rdata[1], 1'b1);
    n = 3;
    while (1) begin
      tick(1);
      if (!ctrl_rdata[1]) break;
      n++;
    end
    chk("R10 busy length unaffected", n, WC);
    chk("R10 latched addr", mem_addr, 9'h133);
    chk("R10 latched data", mem_data, 8'hC7);
    chk("R7 irq after completion", ready_irq, 1'b1);
    tick(3);
    chk("R4 all expected starts seen", expq.size(), 0);
    finish_run();
  end
endmodule